// File: doc/BRIEF.md
# Vector Extended Word Divider

This execution unit carries out the extended word divide on a 128-bit vector. Each source operand is split into four 32-bit word lanes. In every lane the word of the first operand becomes the upper half of a 64-bit dividend, with zeros below it. That dividend is divided by the matching word of the second operand. The low 32 bits of the quotient go into the same lane of the destination. The instruction word chooses between a signed and an unsigned form.

A caller presents the instruction word and both operands and pulses `start_i` for one cycle. The unit decodes the word and ignores the pulse if the word is not one of the two divide encodings. When the word is valid, the unit captures the operands and passes the four lanes one after another through a single radix-2 restoring divider. When the last lane has finished, it presents the full vector and pulses `done_o`. The result stays on `result_o` until the next accepted instruction completes.

Top module: `vext_wdiv`

## Requirements
- R1: After a synchronous reset, `done_o` is 0 and `result_o` is all zeros.
- R2: Unsigned form: the lane result is bits 31:0 of ({32'b0, a} << 32) / {32'b0, b}, where a and b are the lane words.
- R3: Signed form: the lane result is bits 31:0 of the quotient of the sign-extended a shifted left by 32, divided by the sign-extended b. The quotient is truncated toward zero and its sign is the XOR of the signs of a and b. The pair a = 0x80000000, b = 0xFFFFFFFF therefore yields 0.
- R4: Lane k is bits 32k+31:32k of each operand and of the result, for k = 0 to 3. All four lanes are computed independently for every accepted instruction.
- R5: A lane whose divisor word is zero produces 0x00000000, and the unit still completes normally.
- R6: An instruction word is a divide when bits 31:26 equal 000100 and bits 10:0 equal 01110001011 (signed) or 01010001011 (unsigned). Bits 25:11 have no effect.
- R7: A `start_i` pulse with any other instruction word is ignored: no `done_o` follows, and `result_o` keeps its value.
- R8: `done_o` is high for exactly one cycle. It rises 264 clock edges after the edge that accepted the instruction, which is 4 lanes × (64 iterations + 2) cycles.
- R9: A `start_i` pulse that arrives while an instruction is in progress is ignored. The result and the timing of the running instruction are unchanged.
- R10: `result_o` changes only on the cycle in which `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin an instruction |
| instr_i | input | 32 | Instruction word to decode |
| opa_i | input | 128 | First source vector, which supplies the dividend words |
| opb_i | input | 128 | Second source vector, which supplies the divisor words |
| result_o | output | 128 | Quotient vector, held between completions |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench sweeps every pairing of a set of corner words: 0, 1, 2, -1, the most negative word, the most positive word and a few mid-range values. Each pairing runs in both forms, followed by random vectors. A design that mishandled the most negative word would produce a wrong magnitude, and one with a wrong sign rule would return the negated quotient for mixed-sign pairs. A zero divisor is mixed with valid lanes. A design without the zero override would write all ones there, and one that stalled on zero would never raise done. The bench also tries opcodes that are one bit off, a restart while the unit is busy, and exact done timing. These catch a decoder that over-matches, an FSM that re-captures operands, and any lane-sequencing off-by-one.

// File: rtl/vxd_pkg.sv
package vxd_pkg;

  localparam logic [5:0]  PRI_OPC     = 6'b000100;
  localparam logic [10:0] XO_SIGNED   = 11'b01110001011;
  localparam logic [10:0] XO_UNSIGNED = 11'b01010001011;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_WAIT = 2'd2
  } vxd_state_e;

endpackage

// File: rtl/vxd_decode.sv
module vxd_decode
  import vxd_pkg::*;
(
  input  logic [5:0]  pri_i,
  input  logic [10:0] xo_i,
  output logic        valid_o,
  output logic        signed_o
);

  logic pri_hit;

  always_comb begin
    pri_hit  = (pri_i == PRI_OPC);
    signed_o = (xo_i == XO_SIGNED);
    valid_o  = pri_hit && ((xo_i == XO_SIGNED) || (xo_i == XO_UNSIGNED));
  end

endmodule

// File: rtl/vxd_prep.sv
module vxd_prep #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0]   a_i,
  input  logic [WORD_W-1:0]   b_i,
  input  logic                sgn_i,
  output logic [2*WORD_W-1:0] dvd_o,
  output logic [2*WORD_W-1:0] dvs_o,
  output logic                neg_o,
  output logic                zero_o
);

  localparam int unsigned DW = 2 * WORD_W;

  logic [DW-1:0] a_ext, b_ext, a_mag, b_mag;

  always_comb begin
    a_ext  = sgn_i ? {{WORD_W{a_i[WORD_W-1]}}, a_i} : {{WORD_W{1'b0}}, a_i};
    b_ext  = sgn_i ? {{WORD_W{b_i[WORD_W-1]}}, b_i} : {{WORD_W{1'b0}}, b_i};
    a_mag  = (sgn_i && a_i[WORD_W-1]) ? (DW'(0) - a_ext) : a_ext;
    b_mag  = (sgn_i && b_i[WORD_W-1]) ? (DW'(0) - b_ext) : b_ext;
    // the magnitude of a word never exceeds WORD_W bits, so the shift keeps it whole
    dvd_o  = {a_mag[WORD_W-1:0], {WORD_W{1'b0}}};
    dvs_o  = b_mag;
    neg_o  = sgn_i && (a_i[WORD_W-1] ^ b_i[WORD_W-1]);
    zero_o = (b_i == '0);
  end

endmodule

// File: rtl/vxd_divcore.sv
module vxd_divcore #(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] dvd_i,
  input  logic [DW-1:0] dvs_i,
  output logic [DW-1:0] quo_o,
  output logic          fin_o
);

  localparam int unsigned CW = $clog2(DW);

  logic [DW-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q;
  logic [DW:0]   rem_sh, sub;
  logic          ge;

  always_comb begin
    rem_sh = {rem_q, quo_q[DW-1]};
    ge     = (rem_sh >= {1'b0, dvs_q});
    sub    = rem_sh - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        rem_q <= '0;
        quo_q <= dvd_i;
        dvs_q <= dvs_i;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (ge) begin
          rem_q <= sub[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b0};
        end
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(DW - 1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;
  assign fin_o = fin_q;

endmodule

// File: rtl/vext_wdiv.sv
module vext_wdiv
  import vxd_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [31:0]             instr_i,
  input  logic [WORD_W*LANES-1:0] opa_i,
  input  logic [WORD_W*LANES-1:0] opb_i,
  output logic [WORD_W*LANES-1:0] result_o,
  output logic                    done_o
);

  localparam int unsigned VEC_W  = WORD_W * LANES;
  localparam int unsigned DW     = 2 * WORD_W;
  localparam int unsigned LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  vxd_state_e         state_q;
  logic [LIDX_W-1:0]  lane_q;
  logic [VEC_W-1:0]   a_q, b_q, acc_q;
  logic               sgn_q, neg_q, zero_q;

  logic               dec_valid, dec_signed;
  logic [WORD_W-1:0]  a_lane, b_lane, lane_val;
  logic [DW-1:0]      dvd, dvs, quo, quo_fix;
  logic               neg_c, zero_c, load, fin, last;

  vxd_decode u_dec (
    .pri_i    (instr_i[31:26]),
    .xo_i     (instr_i[10:0]),
    .valid_o  (dec_valid),
    .signed_o (dec_signed)
  );

  always_comb begin
    a_lane = a_q[lane_q*WORD_W +: WORD_W];
    b_lane = b_q[lane_q*WORD_W +: WORD_W];
  end

  vxd_prep #(.WORD_W(WORD_W)) u_prep (
    .a_i    (a_lane),
    .b_i    (b_lane),
    .sgn_i  (sgn_q),
    .dvd_o  (dvd),
    .dvs_o  (dvs),
    .neg_o  (neg_c),
    .zero_o (zero_c)
  );

  assign load = (state_q == ST_PREP);

  vxd_divcore #(.DW(DW)) u_core (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .dvd_i  (dvd),
    .dvs_i  (dvs),
    .quo_o  (quo),
    .fin_o  (fin)
  );

  always_comb begin
    quo_fix  = neg_q ? (DW'(0) - quo) : quo;
    lane_val = zero_q ? '0 : quo_fix[WORD_W-1:0];
    last     = (lane_q == LIDX_W'(LANES - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      lane_q   <= '0;
      a_q      <= '0;
      b_q      <= '0;
      acc_q    <= '0;
      sgn_q    <= 1'b0;
      neg_q    <= 1'b0;
      zero_q   <= 1'b0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && dec_valid) begin
            a_q     <= opa_i;
            b_q     <= opb_i;
            sgn_q   <= dec_signed;
            lane_q  <= '0;
            state_q <= ST_PREP;
          end
        end
        ST_PREP: begin
          neg_q   <= neg_c;
          zero_q  <= zero_c;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fin) begin
            for (int l = 0; l < int'(LANES); l++) begin
              if (lane_q == LIDX_W'(l)) acc_q[l*WORD_W +: WORD_W] <= lane_val;
            end
            if (last) begin
              for (int l = 0; l < int'(LANES); l++) begin
                result_o[l*WORD_W +: WORD_W] <= (lane_q == LIDX_W'(l)) ? lane_val
                                                : acc_q[l*WORD_W +: WORD_W];
              end
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              lane_q  <= lane_q + 1'b1;
              state_q <= ST_PREP;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vxd_chk.sv
module vxd_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LANES  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start_i,
  input logic [31:0]             instr_i,
  input logic [WORD_W*LANES-1:0] opb_i,
  input logic [WORD_W*LANES-1:0] result_o,
  input logic                    done_o
);

  localparam int unsigned LAT = LANES * (2 * WORD_W + 2);

  logic                    ck_busy;
  int unsigned             ck_cnt;
  logic [WORD_W*LANES-1:0] ck_b;
  logic                    ck_ok;

  assign ck_ok = (instr_i[31:26] == 6'b000100) &&
                 ((instr_i[10:0] == 11'b01110001011) || (instr_i[10:0] == 11'b01010001011));

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_busy <= 1'b0;
      ck_cnt  <= 0;
      ck_b    <= '0;
    end else if (!ck_busy) begin
      if (start_i && ck_ok) begin
        ck_busy <= 1'b1;
        ck_cnt  <= 0;
        ck_b    <= opb_i;
      end
    end else begin
      ck_cnt <= ck_cnt + 1;
      if (done_o) ck_busy <= 1'b0;
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_time_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ck_busy && ck_cnt == LAT));

  p_done_due_r8: assert property (@(posedge clk) disable iff (rst)
    (ck_busy && ck_cnt == LAT) |-> done_o);

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    !ck_busy |-> !done_o);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  for (genvar l = 0; l < LANES; l++) begin : g_zero
    p_zero_div_r5: assert property (@(posedge clk) disable iff (rst)
      (done_o && ck_b[l*WORD_W +: WORD_W] == '0) |-> (result_o[l*WORD_W +: WORD_W] == '0));
  end

endmodule

bind vext_wdiv vxd_chk #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .instr_i  (instr_i),
  .opb_i    (opb_i),
  .result_o (result_o),
  .done_o   (done_o)
);

// File: tb/vext_wdiv_tb_top.sv
`timescale 1ns/1ps
module vext_wdiv_tb_top;

  localparam int LAT = 264;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic [127:0] opa_i = '0, opb_i = '0;
  logic [127:0] result_o;
  logic         done_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit summary_done = 0;

  always #4 clk = ~clk;

  vext_wdiv dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .instr_i(instr_i),
    .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o), .done_o(done_o)
  );

  function automatic logic [31:0] ref_div(input logic [31:0] a, input logic [31:0] b, input bit sgn);
    logic [63:0] ma, mb, q;
    bit neg;
    if (b == 0) return 32'h0;
    if (sgn) begin
      ma  = a[31] ? (64'd0 - {32'hFFFFFFFF, a}) : {32'h0, a};
      mb  = b[31] ? (64'd0 - {32'hFFFFFFFF, b}) : {32'h0, b};
      neg = a[31] ^ b[31];
    end else begin
      ma  = {32'h0, a};
      mb  = {32'h0, b};
      neg = 0;
    end
    q = (ma << 32) / mb;
    if (neg) q = 64'd0 - q;
    return q[31:0];
  endfunction

  function automatic logic [31:0] mk_ins(input bit sgn, input logic [14:0] regs);
    return {6'b000100, regs, sgn ? 11'b01110001011 : 11'b01010001011};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_op(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b, input bit sgn);
    int cyc;
    logic [127:0] exp;
    @(negedge clk);
    instr_i = ins; opa_i = a; opb_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(cyc);
    check("R8 latency", 128'(cyc), 128'(LAT));
    for (int l = 0; l < 4; l++) begin
      exp[l*32 +: 32] = ref_div(a[l*32 +: 32], b[l*32 +: 32], sgn);
    end
    // R2 unsigned / R3 signed, R4 lane placement, R5 zero divisors
    check(sgn ? "R3 R4 R5 signed lanes" : "R2 R4 R5 unsigned lanes", result_o, exp);
    @(negedge clk);
    check("R8 single-cycle done", 128'(done_o), 128'(0));
  endtask

  logic [31:0] cv [8];

  initial begin
    #(200000 * 8);
    if (!summary_done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, held;
    int cyc;
    bit seen;
    cv[0] = 32'h00000000; cv[1] = 32'h00000001; cv[2] = 32'h00000002; cv[3] = 32'hFFFFFFFF;
    cv[4] = 32'h80000000; cv[5] = 32'h7FFFFFFF; cv[6] = 32'h00000003; cv[7] = 32'hFFFF0005;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset result", result_o, '0);
    check("R1 reset done", 128'(done_o), 128'(0));

    // corner sweep: every pair of corner words, both forms
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 64; p += 4) begin
        for (int l = 0; l < 4; l++) begin
          a[l*32 +: 32] = cv[(p + l) / 8];
          b[l*32 +: 32] = cv[(p + l) % 8];
        end
        run_op(mk_ins(m == 1, 15'(p * 37)), a, b, m == 1);
      end
    end

    // random vectors, some lanes with zero divisor, random register fields (R6)
    for (int k = 0; k < 40; k++) begin
      for (int l = 0; l < 4; l++) begin
        a[l*32 +: 32] = $urandom;
        b[l*32 +: 32] = ($urandom_range(0, 5) == 0) ? 32'h0 : ($urandom >> $urandom_range(0, 28));
      end
      run_op(mk_ins(k[0], 15'($urandom)), a, b, k[0]);
    end

    // R7: near-miss encodings are ignored, result held (R10)
    held = result_o;
    for (int v = 0; v < 3; v++) begin
      @(negedge clk);
      instr_i = (v == 0) ? {6'b000101, 15'h0, 11'b01110001011} :
                (v == 1) ? {6'b000100, 15'h0, 11'b01110001010} :
                           {6'b000100, 15'h0, 11'b01010001111};
      opa_i = '1; opb_i = 128'h1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      seen = 0;
      for (int c = 0; c < LAT + 20; c++) begin
        if (done_o) seen = 1;
        @(negedge clk);
      end
      check("R7 no done for bad opcode", 128'(seen), 128'(0));
      check("R7 R10 result held", result_o, held);
    end

    // R9: restart while busy is ignored
    a = {32'h00000010, 32'h80000000, 32'hFFFFFFF0, 32'h00000007};
    b = {32'h00000003, 32'hFFFFFFFF, 32'h00000004, 32'h00000000};
    @(negedge clk);
    instr_i = mk_ins(1, 15'h0); opa_i = a; opb_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (49) @(negedge clk);
    instr_i = mk_ins(0, 15'h0); opa_i = '1; opb_i = 128'h2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(cyc);
    check("R9 R8 latency kept", 128'(cyc + 50), 128'(LAT));
    for (int l = 0; l < 4; l++) held[l*32 +: 32] = ref_div(a[l*32 +: 32], b[l*32 +: 32], 1);
    check("R9 first operands kept", result_o, held);
    @(negedge clk);
    seen = 0;
    for (int c = 0; c < LAT + 20; c++) begin
      if (done_o) seen = 1;
      @(negedge clk);
    end
    check("R9 no second done", 128'(seen), 128'(0));
    check("R10 result stable when idle", result_o, held);

    summary_done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule